// File: doc/BRIEF.md
# Saw-Wave PWM Timer Channel

One channel of a general-purpose PWM timer. A counter advances on a prescaled count tick. It runs up from zero to a programmable period and wraps, or runs down from the period to zero and reloads. Two output pins, A and B, each follow their own compare register. A per-pin 5-bit action code sets the pin's level when counting starts, what happens at every period boundary, and what happens on a compare match. A code whose compare action toggles and whose boundary action restores the initial level gives a plain PWM waveform. With code 0x1B counting up, the duty cycle is C/(period+1).

Software reaches the channel through a word-addressed register port. Writes are single-cycle and reads are combinational. The mode and prescaler fields can only be changed while the counter is stopped. Stopping the counter drives both pins low. Single-cycle interrupt pulses report compare A, compare B, overflow in up-count mode and underflow in down-count mode.

Top module: `pwmt_channel`

## Requirements
- R1: Registers sit at word addresses equal to the byte offset divided by four:
  - control 0x0B (run bit 0, mode [18:16], prescaler [26:24]);
  - direction 0x0C (bit 0 = 1 counts up, bit 1 stored);
  - pin control 0x0D (pin A code [4:0] and enable bit 8, pin B code [20:16] and enable bit 24);
  - buffer 0x10, counter 0x12, compare A 0x13, compare B 0x14, period 0x19.
  Unused bits and unmapped addresses read 0.
- R2: After reset every register reads 0 except direction, which reads 1 (counting up). Both pins and all four interrupts are low.
- R3: In up-count mode each tick adds one to the counter. A tick taken at a count equal to the period loads 0 and pulses `irq_ovf` in the cycle the counter shows 0.
- R4: The tick comes every 4^n clocks, where n is the prescaler field; the values 6 and 7 act as 5 (divide by 1024). The divider restarts from zero each time counting starts. Without a tick the counter holds.
- R5: In down-count mode each tick subtracts one. Arriving at 0 pulses `irq_unf`, and the tick taken at 0 reloads the period.
- R6: A write to the counter register loads the value at that clock edge and overrides a tick in the same cycle. The load raises no interrupt and changes no pin.
- R7: A control write always updates the run bit. The mode and prescaler fields update only if the run bit was 0 before the write.
- R8: While the mode field is non-zero the counter does not count.
- R9: Pin code bit 4 is the level loaded at start. Bits [3:2] act when a tick crosses the period boundary (wrap or reload), and bits [1:0] act when a tick makes the count equal to the pin's compare value. Actions are 0 keep, 1 low, 2 high, 3 toggle. When both apply on one tick, the boundary action comes first. With code 0x1B and compare C counting up, the pin is high for counts below C. With code 0x07 it is high for counts of C and above.
- R10: `irq_cmp_a` / `irq_cmp_b` pulse for one cycle when a tick makes the counter equal to that pin's compare value.
- R11: A pin is low whenever the run bit is 0 or its enable bit is 0.
- R12: Period and compare writes take effect at once. The buffer register is stored and read back but does not affect counting or the pins.
- R13: Counting up, a tick taken at any count at or above the period wraps to 0 with an overflow pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_a | output | 1 | Output pin A |
| pin_b | output | 1 | Output pin B |
| irq_cmp_a | output | 1 | Compare A match pulse |
| irq_cmp_b | output | 1 | Compare B match pulse |
| irq_ovf | output | 1 | Overflow (up-count wrap) pulse |
| irq_unf | output | 1 | Underflow (down-count reaching 0) pulse |

## Verification
The hardest situations to reach are the collisions between software and counting. These are a counter write landing on the same edge as a tick, a compare value of 0 where the boundary and compare actions fire on one tick, and a counter left above a newly shortened period. The bench reaches each one by starting the channel at a prescale of 1, so a tick falls on every clock and any register write coincides with a tick. It then reads the counter and pins on the following cycles. Sweeps over small periods, every legal compare value, both directions and the prescale settings are checked against counts computed from the elapsed clock count.

// File: rtl/pwmt_pkg.sv
// Shared constants for the PWM timer channel: bus width, register word
// addresses, control field positions and the pin action encoding.
package pwmt_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;

    // Register word addresses (byte offset / 4)
    localparam logic [ADDR_W-1:0] A_CTL  = 6'h0B;
    localparam logic [ADDR_W-1:0] A_DIR  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_IOC  = 6'h0D;
    localparam logic [ADDR_W-1:0] A_BUF  = 6'h10;
    localparam logic [ADDR_W-1:0] A_CNT  = 6'h12;
    localparam logic [ADDR_W-1:0] A_CMPA = 6'h13;
    localparam logic [ADDR_W-1:0] A_CMPB = 6'h14;
    localparam logic [ADDR_W-1:0] A_PRD  = 6'h19;

    // Control field positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_MODE = 16;
    localparam int CTL_PSC  = 24;

    // Pin control field positions
    localparam int IOC_B_OFS  = 16;
    localparam int IOC_OE_OFS = 8;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    // Apply one pin action to a level
    function automatic logic apply_act(input logic [1:0] act, input logic lvl);
        case (pin_act_e'(act))
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~lvl;
            default:    return lvl;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
// Register file of the channel. Holds control, direction, pin control,
// buffer, period and compare registers; decodes counter loads and start.
// Assumes single-cycle writes; reads are a combinational mux on reg_addr.
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic              run,
    output logic [2:0]        mode,
    output logic [2:0]        psc_sel,
    output logic              dir_up,
    output logic [4:0]        code_a,
    output logic              oe_a,
    output logic [4:0]        code_b,
    output logic              oe_b,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic              start,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val,
    output logic [BUS_W-1:0]  rdata
);

    logic             run_q;
    logic [2:0]       mode_q;
    logic [2:0]       psc_q;
    logic [1:0]       dir_q;
    logic [4:0]       code_a_q, code_b_q;
    logic             oe_a_q, oe_b_q;
    logic [BUS_W-1:0] buf_q;
    logic [CNT_W-1:0] prd_q, cmpa_q, cmpb_q;

    logic wr_ctl;
    assign wr_ctl = wr_en && (addr == A_CTL);

    // Register updates; mode and prescaler are locked while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            mode_q   <= '0;
            psc_q    <= '0;
            dir_q    <= 2'b01;
            code_a_q <= '0;
            code_b_q <= '0;
            oe_a_q   <= 1'b0;
            oe_b_q   <= 1'b0;
            buf_q    <= '0;
            prd_q    <= '0;
            cmpa_q   <= '0;
            cmpb_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTL: begin
                    run_q <= wdata[CTL_RUN];
                    if (!run_q) begin
                        mode_q <= wdata[CTL_MODE +: 3];
                        psc_q  <= wdata[CTL_PSC +: 3];
                    end
                end
                A_DIR: dir_q <= wdata[1:0];
                A_IOC: begin
                    code_a_q <= wdata[4:0];
                    oe_a_q   <= wdata[IOC_OE_OFS];
                    code_b_q <= wdata[IOC_B_OFS +: 5];
                    oe_b_q   <= wdata[IOC_B_OFS + IOC_OE_OFS];
                end
                A_BUF:  buf_q  <= wdata;
                A_PRD:  prd_q  <= CNT_W'(wdata);
                A_CMPA: cmpa_q <= CNT_W'(wdata);
                A_CMPB: cmpb_q <= CNT_W'(wdata);
                default: ;
            endcase
        end
    end

    // Readback mux over all mapped registers
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTL: begin
                rdata[CTL_RUN]       = run_q;
                rdata[CTL_MODE +: 3] = mode_q;
                rdata[CTL_PSC +: 3]  = psc_q;
            end
            A_DIR: rdata[1:0] = dir_q;
            A_IOC: begin
                rdata[4:0]                      = code_a_q;
                rdata[IOC_OE_OFS]               = oe_a_q;
                rdata[IOC_B_OFS +: 5]           = code_b_q;
                rdata[IOC_B_OFS + IOC_OE_OFS]   = oe_b_q;
            end
            A_BUF:  rdata = buf_q;
            A_CNT:  rdata = BUS_W'(cnt_val);
            A_CMPA: rdata = BUS_W'(cmpa_q);
            A_CMPB: rdata = BUS_W'(cmpb_q);
            A_PRD:  rdata = BUS_W'(prd_q);
            default: rdata = '0;
        endcase
    end

    assign run        = run_q;
    assign mode       = mode_q;
    assign psc_sel    = psc_q;
    assign dir_up     = dir_q[0];
    assign code_a     = code_a_q;
    assign oe_a       = oe_a_q;
    assign code_b     = code_b_q;
    assign oe_b       = oe_b_q;
    assign period     = prd_q;
    assign cmp_a      = cmpa_q;
    assign cmp_b      = cmpb_q;
    assign start      = wr_ctl && wdata[CTL_RUN] && !run_q;
    assign cnt_ld     = wr_en && (addr == A_CNT);
    assign cnt_ld_val = CNT_W'(wdata);

    // Mode and prescaler cannot move while the counter runs
    p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> ($stable(mode_q) && $stable(psc_q)));

endmodule

// File: rtl/pwmt_prescale.sv
// Count-tick generator: one tick every 4^n clocks, n taken from the
// prescaler field and clamped to PSC_SEL_MAX. The divider is held at zero
// while counting is disabled so every start begins a fresh division.
module pwmt_prescale #(
    parameter int PSC_SEL_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic [2:0] sel,
    output logic       tick
);

    localparam int PSC_W = 2 * PSC_SEL_MAX;

    logic [PSC_W-1:0] pre_q;
    logic [PSC_W-1:0] lim;
    int               sel_c;

    // Terminal count 4^n - 1 built as n pairs of ones
    always_comb begin
        sel_c = (int'(sel) > PSC_SEL_MAX) ? PSC_SEL_MAX : int'(sel);
        lim   = '0;
        for (int i = 0; i < PSC_SEL_MAX; i++) begin
            if (i < sel_c) lim[2*i +: 2] = 2'b11;
        end
    end

    assign tick = cnt_en && (pre_q == lim);

    // Divider count, cleared when idle or on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !cnt_en || tick) pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
    end

    // The divider never passes its terminal count
    p_div_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && $stable(sel) && !tick) |=> (pre_q <= lim));

endmodule

// File: rtl/pwmt_counter.sv
// Saw-wave counter: counts up to the period and wraps to 0, or counts down
// to 0 and reloads the period. Software loads win over ticks. Produces the
// next value, step and boundary flags for the pins, and the wrap interrupts.
module pwmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             up,
    input  logic [CNT_W-1:0] period,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             step,
    output logic             cyc_end,
    output logic             irq_ovf,
    output logic             irq_unf
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q, unf_q;

    // Next count and boundary detection for the selected direction
    always_comb begin
        if (up) begin
            cyc_end = (cnt_q >= period);
            nxt     = cyc_end ? '0 : cnt_q + 1'b1;
        end else begin
            cyc_end = (cnt_q == '0);
            nxt     = cyc_end ? period : cnt_q - 1'b1;
        end
    end

    assign step = tick && !ld_en;

    // Counter register: load has priority over counting
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ld_en) cnt_q <= ld_val;
        else if (step)  cnt_q <= nxt;
    end

    // Overflow / underflow pulses aligned with the counter showing 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= step && up && cyc_end;
            unf_q <= step && !up && (nxt == '0);
        end
    end

    assign cnt     = cnt_q;
    assign irq_ovf = ovf_q;
    assign irq_unf = unf_q;

    p_ovf_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));
    p_unf_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> (cnt_q == '0));
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cnt_q == $past(ld_val)));
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_en) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmt_pin.sv
// One output pin: holds a level driven by the 5-bit action code (initial
// level, boundary action, compare action) and raises the compare pulse.
// Assumes start is only asserted while the counter is stopped.
module pwmt_pin
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             oe,
    input  logic [4:0]       code,
    input  logic [CNT_W-1:0] cmp,
    input  logic             start,
    input  logic             step,
    input  logic             cyc_end,
    input  logic [CNT_W-1:0] nxt,
    output logic             pin,
    output logic             irq_cmp
);

    logic lvl_q, irq_q, match;
    logic lvl_b, lvl_n;

    assign match = (nxt == cmp);

    // Boundary action first, then compare action
    always_comb begin
        lvl_b = cyc_end ? apply_act(code[3:2], lvl_q) : lvl_q;
        lvl_n = match ? apply_act(code[1:0], lvl_b) : lvl_b;
    end

    // Pin level register and compare interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (start)     lvl_q <= code[4];
            else if (step) lvl_q <= lvl_n;
            irq_q <= step && match;
        end
    end

    assign pin     = run && oe && lvl_q;
    assign irq_cmp = irq_q;

    // A compare pulse never appears without a step in the cycle before
    p_cmp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(step));

endmodule

// File: rtl/pwmt_channel.sv
// Top of one saw-wave PWM timer channel: register file, prescaler, counter
// and two pin instances. Counting runs only with the run bit set and mode 0.
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PSC_SEL_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              pin_a,
    output logic              pin_b,
    output logic              irq_cmp_a,
    output logic              irq_cmp_b,
    output logic              irq_ovf,
    output logic              irq_unf
);

    localparam int NPIN = 2;

    logic             run, dir_up, start, cnt_ld, tick, step, cyc_end;
    logic [2:0]       mode, psc_sel;
    logic [CNT_W-1:0] period, cnt, nxt, cnt_ld_val;
    logic [4:0]       code [NPIN];
    logic             oe   [NPIN];
    logic [CNT_W-1:0] cmp  [NPIN];
    logic             pin  [NPIN];
    logic             icmp [NPIN];

    pwmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .cnt_val    (cnt),
        .run        (run),
        .mode       (mode),
        .psc_sel    (psc_sel),
        .dir_up     (dir_up),
        .code_a     (code[0]),
        .oe_a       (oe[0]),
        .code_b     (code[1]),
        .oe_b       (oe[1]),
        .period     (period),
        .cmp_a      (cmp[0]),
        .cmp_b      (cmp[1]),
        .start      (start),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .rdata      (reg_rdata)
    );

    pwmt_prescale #(.PSC_SEL_MAX(PSC_SEL_MAX)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (run && (mode == 3'd0)),
        .sel    (psc_sel),
        .tick   (tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .up      (dir_up),
        .period  (period),
        .ld_en   (cnt_ld),
        .ld_val  (cnt_ld_val),
        .cnt     (cnt),
        .nxt     (nxt),
        .step    (step),
        .cyc_end (cyc_end),
        .irq_ovf (irq_ovf),
        .irq_unf (irq_unf)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pwmt_pin #(.CNT_W(CNT_W)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .oe      (oe[g]),
            .code    (code[g]),
            .cmp     (cmp[g]),
            .start   (start),
            .step    (step),
            .cyc_end (cyc_end),
            .nxt     (nxt),
            .pin     (pin[g]),
            .irq_cmp (icmp[g])
        );
    end

    assign pin_a     = pin[0];
    assign pin_b     = pin[1];
    assign irq_cmp_a = icmp[0];
    assign irq_cmp_b = icmp[1];

    // Pins are low in any cycle the counter is stopped
    p_stop_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> (!pin_a && !pin_b));

endmodule

// File: tb/pwmt_channel_tb.sv
module pwmt_channel_tb;

    localparam logic [5:0] R_CTL = 6'h0B, R_DIR = 6'h0C, R_IOC = 6'h0D,
                           R_BUF = 6'h10, R_CNT = 6'h12, R_CMPA = 6'h13,
                           R_CMPB = 6'h14, R_PRD = 6'h19;
    localparam logic [31:0] IOC_STD = 32'h0107_011B; // A: 0x1B+en, B: 0x07+en

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pin_a, pin_b, irq_cmp_a, irq_cmp_b, irq_ovf, irq_unf;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwmt_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a(pin_a),
        .pin_b(pin_b), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b),
        .irq_ovf(irq_ovf), .irq_unf(irq_unf)
    );

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Sample {counter, pins, interrupts} at the current negedge
    task automatic sample(output logic [37:0] v);
        logic [31:0] c;
        rd(R_CNT, c);
        v = {c, pin_a, pin_b, irq_cmp_a, irq_cmp_b, irq_ovf, irq_unf};
    endtask

    // Program, start and sweep one configuration against arithmetic expectation
    task automatic run_cfg(string req, bit up, int P, int n, int ca, int cb,
                           int bufv, int ncyc);
        int D;
        logic [37:0] v, e;
        D = 1 << (2 * ((n > 5) ? 5 : n));
        wr(R_CTL, 0);
        wr(R_PRD, P);
        wr(R_CMPA, ca);
        wr(R_CMPB, cb);
        wr(R_IOC, IOC_STD);
        wr(R_DIR, up ? 3 : 2);
        wr(R_BUF, bufv);
        wr(R_CTL, n << 24);
        wr(R_CNT, up ? 0 : P);
        wr(R_CTL, (n << 24) | 1);
        for (int k = 0; k <= ncyc; k++) begin
            int  t, c;
            bit  st, ea, eb;
            t  = (k / D) % (P + 1);
            c  = up ? t : P - t;
            st = (k > 0) && (k % D == 0);
            ea = up ? (c < ca) : (c > ca);
            eb = up ? (c >= cb) : (c <= cb);
            e  = {32'(c), ea, eb, st && (c == ca), st && (c == cb),
                  st && up && (c == 0), st && !up && (c == 0)};
            sample(v);
            check(req, 64'(v), 64'(e));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [37:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        rd(R_CTL, d);  check("R2 ctl", d, 0);
        rd(R_DIR, d);  check("R2 dir", d, 1);
        rd(R_IOC, d);  check("R2 ioc", d, 0);
        rd(R_PRD, d);  check("R2 period", d, 0);
        rd(R_CNT, d);  check("R2 counter", d, 0);
        check("R2 outputs", {pin_a, pin_b, irq_cmp_a, irq_cmp_b, irq_ovf, irq_unf}, 0);

        // R1: field layout and unmapped addresses
        wr(R_IOC, 32'hFFFF_FFFF); rd(R_IOC, d); check("R1 ioc fields", d, 32'h011F_011F);
        wr(R_CTL, 32'hFFFF_FFFE); rd(R_CTL, d); check("R1 ctl fields", d, 32'h0707_0000);
        wr(R_CTL, 0);
        wr(R_CMPB, 32'h1234_5678); rd(R_CMPB, d); check("R1 cmpb", d, 32'h1234_5678);
        rd(6'h00, d); check("R1 unmapped", d, 0);
        wr(R_BUF, 32'hA5); rd(R_BUF, d); check("R1 R12 buffer readback", d, 32'hA5);

        // R3 R9 R10: up-count sweep, every period 0..5 and every compare 1..P+1
        for (int P = 0; P <= 5; P++)
            for (int ca = 1; ca <= P + 1; ca++)
                run_cfg("R3 R9 R10 up sweep", 1'b1, P, 0, ca, P + 2 - ca, 0, 3 * (P + 1) + 2);

        // R4: prescaler 4, 16, 1024 and clamped field 7
        run_cfg("R4 div4", 1'b1, 3, 1, 2, 1, 0, 40);
        run_cfg("R4 div16", 1'b1, 3, 2, 2, 3, 0, 140);
        run_cfg("R4 div1024", 1'b1, 1, 5, 1, 1, 0, 2100);
        run_cfg("R4 sel7 clamp", 1'b1, 1, 7, 1, 2, 0, 2100);

        // R5 R12: down-count sweep, buffer register set to non-zero
        for (int P = 2; P <= 5; P++)
            for (int ca = 1; ca <= P - 1; ca++)
                run_cfg("R5 R12 down sweep", 1'b0, P, 0, ca, P - ca, 32'hFF, 3 * (P + 1) + 2);
        run_cfg("R5 R4 down div4", 1'b0, 3, 1, 1, 2, 0, 40);

        // R9: compare 0 with code 0x1B: boundary high then compare toggle low
        wr(R_CTL, 0); wr(R_PRD, 2); wr(R_CMPA, 0); wr(R_CMPB, 9);
        wr(R_IOC, IOC_STD); wr(R_DIR, 3); wr(R_CNT, 0); wr(R_CTL, 1);
        @(negedge clk); @(negedge clk);
        check("R9 cmp0 first period", pin_a, 1'b1);
        @(negedge clk);
        check("R9 cmp0 after wrap", {pin_a, irq_cmp_a, irq_ovf}, 3'b011);

        // R6: counter write colliding with a tick, with compare equal to the load
        wr(R_CTL, 0); wr(R_PRD, 100); wr(R_CMPA, 50); wr(R_CNT, 0); wr(R_CTL, 1);
        repeat (3) @(negedge clk);
        wr(R_CNT, 50);
        sample(v);
        check("R6 load over tick", {v[37:6], v[3]}, {32'd50, 1'b0});
        check("R6 load keeps pin", pin_a, 1'b1);
        @(negedge clk);
        rd(R_CNT, d); check("R6 counts after load", d, 51);

        // R12 R13: shorten the period below the current count
        wr(R_PRD, 3);
        @(negedge clk);
        sample(v);
        check("R12 R13 wrap above period", {v[37:6], v[1]}, {32'd0, 1'b1});

        // R7: mode and prescaler locked while running
        wr(R_CTL, 0); wr(R_CTL, 32'h0100_0000); wr(R_CTL, 32'h0100_0001);
        wr(R_CTL, 32'h0302_0001); rd(R_CTL, d); check("R7 locked while run", d, 32'h0100_0001);
        wr(R_CTL, 32'h0300_0000); rd(R_CTL, d); check("R7 stop write locked", d, 32'h0100_0000);
        wr(R_CTL, 32'h0300_0000); rd(R_CTL, d); check("R7 accepted when stopped", d, 32'h0300_0000);

        // R8: non-zero mode holds the counter
        wr(R_CTL, 32'h0001_0000); wr(R_CNT, 5); wr(R_CTL, 32'h0001_0001);
        repeat (8) @(negedge clk);
        rd(R_CNT, d); check("R8 mode hold", d, 5);
        wr(R_CTL, 0); wr(R_CTL, 0);

        // R11: enable bit and stop force the pins low
        wr(R_PRD, 100); wr(R_CMPA, 200); wr(R_CMPB, 0); wr(R_IOC, IOC_STD);
        wr(R_CNT, 0); wr(R_CTL, 1);
        check("R11 pin a high", pin_a, 1'b1);
        wr(R_IOC, 32'h0107_001B);
        check("R11 enable cleared", pin_a, 1'b0);
        wr(R_IOC, IOC_STD);
        check("R11 enable restored", pin_a, 1'b1);
        wr(R_CTL, 0);
        check("R11 stopped pins", {pin_a, pin_b}, 2'b00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule